// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block runs a group of analog-to-digital conversions chosen by a channel mask. Software writes a mask with one bit per analog input, then pulses a trigger. The sequencer walks the set bits from the lowest index upward. For each one it sends a start request with the channel number to the converter and waits for the done strobe. It then writes a result entry to a results buffer through a write port. The write pointer wraps at the buffer depth.

A down-counting threshold counter tracks stored results. When it runs out, the block raises a one-cycle interrupt pulse. If enabled, it also raises a block-transfer request in the same cycle. Rewriting the mask while a scan runs either halts the scan or restarts it, depending on the value written.

A small register port holds the mask, the threshold counter, a control bit and the read-only write pointer. Reads are combinational from the address.

Top module: `adc_scan_seq`

## Requirements
- R1: The mask register sits at register address 0 and holds one bit per channel in bits NUM_CH-1:0. Bits 31:NUM_CH always read as zero, and writes to them are dropped.
- R2: A trigger while the mask is all zeros issues no conversion and stores no result.
- R3: A trigger in idle converts each channel whose mask bit is 1, one at a time, from the lowest index to the highest. Each conversion is a one-cycle `conv_start` with `conv_ch`, followed by a wait for `conv_done`.
- R4: Each result is written with `buf_we` at `buf_addr` equal to the write pointer. The entry `buf_wdata` carries the channel index in its upper CH_W bits and the converter data in the lower DATA_W bits. The pointer then advances by one, wrapping from BUF_DEPTH-1 to 0. It reads back at register address 3.
- R5: Writing zero to the mask during a scan stops the scan: no further starts and no further stores. The write pointer and the threshold count are left as they were.
- R6: Writing a non-zero mask during a scan restarts the scan from the lowest set bit of the new mask and sets the write pointer to 0. The result of a conversion that was in flight is never stored.
- R7: A non-zero mask write during a scan leaves the threshold count unchanged.
- R8: Writing register address 1 loads the threshold counter. Each stored result decrements it, and it never goes below zero. When a store takes it from 1 to 0, `thr_irq` pulses for one cycle, one cycle after that store. `blk_req` pulses in the same cycle if bit 0 of register address 2 is set.
- R9: A trigger during a scan is ignored. After the highest selected channel is stored, the block goes idle and accepts the next trigger.
- R10: A mask write while idle starts no conversion and leaves the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 threshold, 2 control, 3 pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| trig | input | 1 | Group trigger |
| conv_start | output | 1 | Conversion request pulse |
| conv_ch | output | CH_W | Channel to convert |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | DATA_W | Converted value, valid with `conv_done` |
| buf_we | output | 1 | Result buffer write enable |
| buf_addr | output | PTR_W | Result buffer write address |
| buf_wdata | output | CH_W+DATA_W | Result entry {channel, data} |
| thr_irq | output | 1 | Threshold interrupt pulse |
| blk_req | output | 1 | Block-transfer request pulse |

## Verification
The bench uses 24 channels, 12-bit data and a threshold counter of 6 bits. The buffer depth is shrunk to 8 entries. With that depth, the full 24-channel scan and the back-to-back table scans wrap the write pointer several times, so the wrap from 7 to 0 is exercised repeatedly. With 24 channels, the highest index and a fully set mask are also covered.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } scan_st_e;

  localparam logic [1:0] RA_MASK = 2'd0;
  localparam logic [1:0] RA_THR  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_PTR  = 2'd3;
endpackage

// File: rtl/scan_lowest_pick.sv
module scan_lowest_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [N-1:0] below;
  logic [N-1:0] onehot;

  // below[i] is set when any bit under position i is set
  generate
    for (genvar i = 0; i < N; i++) begin : g_below
      if (i == 0) begin : g_first
        assign below[i] = 1'b0;
      end else begin : g_rest
        assign below[i] = below[i-1] | vec[i-1];
      end
    end
  endgenerate

  assign onehot = vec & ~below;
  assign found  = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/scan_thr_cnt.sv
module scan_thr_cnt #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [THR_W-1:0] load_val,
  input  logic             dec,
  input  logic             blk_en,
  output logic [THR_W-1:0] cnt,
  output logic             irq,
  output logic             blk
);
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             irq_q, blk_q, hit;

  assign hit = dec && !load && (cnt_q == THR_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                         cnt_d = load_val;
    else if (dec && cnt_q != '0)      cnt_d = cnt_q - THR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= hit;
      blk_q <= hit && blk_en;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
  assign blk = blk_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH    = 24,
  parameter int DATA_W    = 12,
  parameter int BUF_DEPTH = 16,
  parameter int THR_W     = 8,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int PTR_W    = $clog2(BUF_DEPTH),
  localparam int ENT_W    = CH_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              buf_we,
  output logic [PTR_W-1:0]  buf_addr,
  output logic [ENT_W-1:0]  buf_wdata,
  output logic              thr_irq,
  output logic              blk_req
);
  logic rst_meta, rst_sync;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  scan_st_e          st_q, st_d;
  logic [NUM_CH-1:0] mask_q, mask_d, pend_q, pend_d, pend_left;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              dma_en_q, dma_en_d;
  logic              mask_wr, busy, store, pick_found;
  logic [CH_W-1:0]   pick_idx;
  logic [NUM_CH-1:0] new_mask;
  logic [THR_W-1:0]  thr_cnt;

  assign mask_wr  = reg_we && (reg_addr == RA_MASK);
  assign new_mask = reg_wdata[NUM_CH-1:0];
  assign busy     = (st_q != ST_IDLE);
  assign store    = (st_q == ST_WAIT) && conv_done && !mask_wr;
  assign pend_left = pend_q & ~(NUM_CH'(1) << ch_q);

  scan_lowest_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
    .vec   (pend_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  scan_thr_cnt #(.THR_W(THR_W)) u_thr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (reg_we && (reg_addr == RA_THR)),
    .load_val (reg_wdata[THR_W-1:0]),
    .dec      (store),
    .blk_en   (dma_en_q),
    .cnt      (thr_cnt),
    .irq      (thr_irq),
    .blk      (blk_req)
  );

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    ptr_d    = ptr_q;
    ch_d     = ch_q;
    mask_d   = mask_q;
    dma_en_d = dma_en_q;

    case (st_q)
      ST_IDLE: begin
        if (trig && (mask_q != '0)) begin
          pend_d = mask_q;
          st_d   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (pick_found) begin
          ch_d = pick_idx;
          st_d = ST_WAIT;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (store) begin
          ptr_d  = (ptr_q == PTR_W'(BUF_DEPTH - 1)) ? '0 : ptr_q + PTR_W'(1);
          pend_d = pend_left;
          st_d   = (pend_left != '0) ? ST_REQ : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (mask_wr) begin
      mask_d = new_mask;
      if (new_mask == '0) begin
        pend_d = '0;
        st_d   = ST_IDLE;
      end else if (busy) begin
        pend_d = new_mask;
        ptr_d  = '0;
        st_d   = ST_REQ;
      end
    end

    if (reg_we && (reg_addr == RA_CTRL)) dma_en_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q     <= ST_IDLE;
      pend_q   <= '0;
      ptr_q    <= '0;
      ch_q     <= '0;
      mask_q   <= '0;
      dma_en_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      ptr_q    <= ptr_d;
      ch_q     <= ch_d;
      mask_q   <= mask_d;
      dma_en_q <= dma_en_d;
    end
  end

  assign conv_start = (st_q == ST_REQ) && pick_found && !mask_wr;
  assign conv_ch    = pick_idx;
  assign buf_we     = store;
  assign buf_addr   = ptr_q;
  assign buf_wdata  = {ch_q, conv_data};

  always_comb begin
    case (reg_addr)
      RA_MASK: reg_rdata = 32'(mask_q);
      RA_THR:  reg_rdata = 32'(thr_cnt);
      RA_CTRL: reg_rdata = 32'(dma_en_q);
      default: reg_rdata = 32'(ptr_q);
    endcase
  end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst_sync,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_ch,
  input logic              buf_we,
  input logic              thr_irq,
  input logic              blk_req,
  input logic              busy,
  input logic [NUM_CH-1:0] mask_q,
  input logic [PTR_W-1:0]  ptr_q
);
  logic zero_wr, restart_wr;
  assign zero_wr    = reg_we && (reg_addr == 2'd0) && (reg_wdata[NUM_CH-1:0] == '0);
  assign restart_wr = reg_we && (reg_addr == 2'd0) && (reg_wdata[NUM_CH-1:0] != '0) && busy;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    (reg_addr == 2'd0) |-> (reg_rdata[31:NUM_CH] == '0)); // R1
  AST_START_SELECTED: assert property (@(posedge clk) disable iff (!rst_sync)
    conv_start |-> mask_q[conv_ch]); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_sync)
    conv_start |=> !conv_start); // R3
  AST_ZERO_HALT: assert property (@(posedge clk) disable iff (!rst_sync)
    zero_wr |=> (!conv_start && !buf_we && $stable(ptr_q))); // R5
  AST_RESTART_PTR: assert property (@(posedge clk) disable iff (!rst_sync)
    restart_wr |=> (ptr_q == '0 && !buf_we)); // R6
  AST_BLK_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_sync)
    blk_req |-> thr_irq); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sync)
    thr_irq |=> !thr_irq); // R8
endmodule

bind adc_scan_seq adc_scan_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .PTR_W  (PTR_W)
) u_chk (
  .clk        (clk),
  .rst_sync   (rst_sync),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .conv_start (conv_start),
  .conv_ch    (conv_ch),
  .buf_we     (buf_we),
  .thr_irq    (thr_irq),
  .blk_req    (blk_req),
  .busy       (busy),
  .mask_q     (mask_q),
  .ptr_q      (ptr_q)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 24;
  localparam int DATA_W = 12;
  localparam int BUF_DEPTH = 8;
  localparam int THR_W = 6;
  localparam int CH_W = 5;
  localparam int PTR_W = 3;
  localparam int LAT = 4;

  // {mask, expected count, expected first channel}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {24'h000001, 5'd1,  5'd0},
    {24'h800000, 5'd1,  5'd23},
    {24'h0000A5, 5'd4,  5'd0},
    {24'h00F00F, 5'd8,  5'd0},
    {24'h0A0000, 5'd2,  5'd17},
    {24'hFFFFFF, 5'd24, 5'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic trig = 1'b0;
  logic conv_start;
  logic [CH_W-1:0] conv_ch;
  logic conv_done = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic buf_we;
  logic [PTR_W-1:0] buf_addr;
  logic [CH_W+DATA_W-1:0] buf_wdata;
  logic thr_irq, blk_req;

  int n_chk = 0, n_fail = 0;
  int st_cnt = 0, irq_cnt = 0, blk_cnt = 0, irq_at = -1;
  int rec_ch [512];
  int rec_addr [512];
  int rec_data [512];
  int stub_cnt = 0;
  logic [CH_W-1:0] stub_ch = '0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .THR_W(THR_W)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig(trig), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .thr_irq(thr_irq), .blk_req(blk_req));

  function automatic int dfun(int ch);
    return (ch * 37 + 5) % 4096;
  endfunction

  // behavioural converter: a new start supersedes one in flight
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      stub_cnt <= LAT;
      stub_ch  <= conv_ch;
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        conv_done <= 1'b1;
        conv_data <= DATA_W'(dfun(int'(stub_ch)));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && buf_we && st_cnt < 512) begin
      rec_ch[st_cnt]   = int'(buf_wdata[CH_W+DATA_W-1:DATA_W]);
      rec_data[st_cnt] = int'(buf_wdata[DATA_W-1:0]);
      rec_addr[st_cnt] = int'(buf_addr);
      st_cnt++;
    end
    if (rst_n && thr_irq) begin irq_cnt++; irq_at = st_cnt; end
    if (rst_n && blk_req) blk_cnt++;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_stores(int target);
    for (int i = 0; i < 2000 && st_cnt < target; i++) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v, p0, t0;
    int base, exp_ptr, k, ok, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // reset state
    rd(2'd0, v); chk(v == 0, "R1 reset mask", v, 0);
    rd(2'd3, v); chk(v == 0, "R4 reset pointer", v, 0);
    rd(2'd1, v); chk(v == 0, "R8 reset threshold", v, 0);
    chk(!conv_start && !buf_we && !thr_irq && !blk_req, "R3 reset outputs", conv_start, 0);

    // R1 reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h00FF_FFFF, "R1 reserved bits read zero", v, 32'h00FF_FFFF);

    // R2 zero mask trigger
    wr(2'd0, 32'h0);
    s0 = st_cnt;
    pulse_trig(); idle(30);
    chk(st_cnt == s0, "R2 zero mask stores", st_cnt - s0, 0);

    // table-driven scans, pointer continues across scans
    exp_ptr = 0;
    for (int e = 0; e < NV; e++) begin
      logic [23:0] m;
      int ecnt, efirst;
      m = VEC[e][33:10]; ecnt = int'(VEC[e][9:5]); efirst = int'(VEC[e][4:0]);
      rd(2'd3, p0);
      base = st_cnt;
      wr(2'd0, 32'(m));
      idle(10);
      rd(2'd3, v);
      chk(st_cnt == base && v == p0, "R10 idle mask write", st_cnt - base, 0);
      pulse_trig();
      wait_stores(base + ecnt);
      idle(20);
      chk(st_cnt - base == ecnt, "R3 store count", st_cnt - base, ecnt);
      chk(rec_ch[base] == efirst, "R3 first channel", rec_ch[base], efirst);
      ok = 1; k = 0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (m[c]) begin
          if (rec_ch[base+k] != c || rec_data[base+k] != dfun(c) ||
              rec_addr[base+k] != (exp_ptr + k) % BUF_DEPTH) ok = 0;
          k++;
        end
      end
      chk(ok == 1, "R4 entries order/addr/data", ok, 1);
      exp_ptr = (exp_ptr + ecnt) % BUF_DEPTH;
      rd(2'd3, v); chk(v == exp_ptr, "R4 pointer after scan", v, exp_ptr);
    end

    // R9 retrigger ignored, then accepted again once idle
    wr(2'd0, 32'h0F);
    base = st_cnt;
    pulse_trig();
    wait_stores(base + 1);
    pulse_trig();
    wait_stores(base + 4); idle(40);
    chk(st_cnt - base == 4, "R9 retrigger ignored", st_cnt - base, 4);
    pulse_trig(); wait_stores(base + 8); idle(20);
    chk(st_cnt - base == 8 && rec_ch[base+4] == 0, "R9 new scan after idle", st_cnt - base, 8);

    // R8 threshold with block request enabled
    wr(2'd2, 32'h1);
    wr(2'd1, 32'd3);
    irq_cnt = 0; blk_cnt = 0; base = st_cnt;
    wr(2'd0, 32'h1F);
    pulse_trig(); wait_stores(base + 5); idle(20);
    chk(irq_cnt == 1, "R8 irq pulses", irq_cnt, 1);
    chk(blk_cnt == 1, "R8 block request pulses", blk_cnt, 1);
    chk(irq_at - base == 3, "R8 irq after third store", irq_at - base, 3);
    rd(2'd1, v); chk(v == 0, "R8 count saturates at zero", v, 0);

    // R8 block request disabled
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd2);
    irq_cnt = 0; blk_cnt = 0; base = st_cnt;
    wr(2'd0, 32'h3);
    pulse_trig(); wait_stores(base + 2); idle(20);
    chk(irq_cnt == 1 && blk_cnt == 0, "R8 irq without block request", blk_cnt, 0);

    // R5 zero write mid-scan
    wr(2'd1, 32'd20);
    wr(2'd0, 32'hFF);
    rd(2'd3, p0);
    base = st_cnt;
    pulse_trig(); wait_stores(base + 2);
    wr(2'd0, 32'h0);
    idle(40);
    chk(st_cnt - base == 2, "R5 halt stores", st_cnt - base, 2);
    rd(2'd3, v); chk(v == (p0 + 2) % BUF_DEPTH, "R5 pointer kept", v, (p0 + 2) % BUF_DEPTH);
    rd(2'd1, t0); chk(t0 == 18, "R5 threshold kept", t0, 18);

    // R6/R7 non-zero write mid-scan
    wr(2'd0, 32'hF0);
    base = st_cnt;
    pulse_trig(); wait_stores(base + 1);
    wr(2'd0, 32'h0C);
    wait_stores(base + 3); idle(40);
    chk(st_cnt - base == 3, "R6 stores after restart", st_cnt - base, 3);
    chk(rec_ch[base+1] == 2 && rec_addr[base+1] == 0, "R6 restart lowest channel at 0", rec_ch[base+1], 2);
    chk(rec_ch[base+2] == 3 && rec_addr[base+2] == 1, "R6 second entry", rec_ch[base+2], 3);
    rd(2'd3, v); chk(v == 2, "R6 pointer after restart", v, 2);
    rd(2'd1, v); chk(v == 15, "R7 threshold not reloaded", v, 15);

    finish_run();
  end
endmodule